// File: doc/BRIEF.md
# ISA DMA Channel Address Sequencer

This block is the address engine of one channel of an ISA-style DMA controller. It holds the channel's page value, its base and current word/byte address, and its base and current count. From these it produces the physical memory address for each transfer. A separate register controller writes the channel registers through simple load strobes and owns the channel mask. The controller also tells the sequencer whether the mask is set, whether the channel is 8-bit or 16-bit, and which 16-bit page mode to use.

Every accepted transfer strobe is acknowledged in the same cycle, with the physical address on the output. On the following clock edge the current address steps up or down by one unit and the count drops by one. When the count is already zero, that transfer is the last of the block. On the last transfer the sequencer does one of two things. If autoinitialise is set, it reloads the current registers from the base registers. If it is not set, it leaves the count at all ones and asks the controller to mask the channel.

A 16-bit channel counts words, so its byte address is the address register shifted left by one. The window the address wraps in depends on the page mode. In 128KB mode the low page bit is dropped and the offset wraps in 128KB. In 64KB mode all page bits are kept and the offset wraps in 64KB.

Top module: `isa_dma_addr_seq`

## Requirements
- R1: After reset the current address, current count, page and base registers are zero, autoinitialise is off, the direction is increment and the terminal-count flag is clear.
- R2: On an 8-bit channel (`chan_wide`=0), `phys_addr` = {page, current address}. The address wraps from 0xFFFF to 0x0000 without changing the page.
- R3: The unit moves at the current address first; the address steps on the next edge, +1 when `mode_dec`=0 and −1 when `mode_dec`=1, wrapping modulo 2^16.
- R4: In 128KB mode, a 16-bit channel gives `phys_addr` = {page[7:1], address[15:0], 1'b0}.
- R5: In 64KB mode, a 16-bit channel gives `phys_addr` = {page[7:0], address[14:0], 1'b0}, so address bit 15 has no effect.
- R6: `cfg_win_sel` selects the page mode. 1 forces 128KB mode and 2 forces 64KB mode. 0 or 3 selects automatically: 64KB mode when `plat_pci`=1, and 128KB mode when `plat_pci`=0.
- R7: A loaded count N gives N+1 acknowledged transfers. `tc_pulse` is high only on the last of them, which is the one accepted while the current count is zero.
- R8: On the last transfer with autoinitialise set, the current address and count reload from the base values. `mask_req` stays low.
- R9: On the last transfer without autoinitialise, `mask_req` pulses with `tc_pulse`, the count becomes 0xFFFF and the address still steps.
- R10: `tc_flag` is set by every terminal count and holds until `stat_rd`. A terminal count in the same cycle as `stat_rd` leaves it set.
- R11: While `chan_masked`=1, `xfer_req` is ignored: `xfer_ack` stays low and the address and count do not change.
- R12: `ld_addr_en` writes both base and current address, and `ld_cnt_en` writes both base and current count. A load takes priority over a transfer step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_wide | input | 1 | 1 for a 16-bit channel |
| cfg_win_sel | input | 2 | Page mode select: 0/3 auto, 1 = 128KB, 2 = 64KB |
| plat_pci | input | 1 | Platform flag used by automatic selection |
| ld_page_en | input | 1 | Load page register |
| ld_addr_en | input | 1 | Load base and current address |
| ld_cnt_en | input | 1 | Load base and current count |
| ld_mode_en | input | 1 | Load autoinitialise and direction |
| ld_data | input | 16 | Load value (page uses the low 8 bits) |
| mode_auto | input | 1 | Autoinitialise value for a mode load |
| mode_dec | input | 1 | Direction value for a mode load (1 = decrement) |
| chan_masked | input | 1 | Channel mask from the controller |
| stat_rd | input | 1 | Status read, clears the terminal-count flag |
| xfer_req | input | 1 | Per-transfer strobe |
| xfer_ack | output | 1 | Transfer accepted this cycle |
| phys_addr | output | 24 | Physical byte address, valid with `xfer_ack` |
| tc_pulse | output | 1 | Last transfer of the block |
| mask_req | output | 1 | Request to set the channel mask (transfer end) |
| tc_flag | output | 1 | Sticky terminal-count flag |
| cur_cnt | output | 16 | Current count |

## Verification
The hardest case to reach is a 16-bit wrap where the two page modes give different addresses. That needs a page value and a current address near a window edge, run under each `cfg_win_sel` setting and both `plat_pci` values. The bench loads a page of 0x35 with addresses 0xFFFF and 0x7FFF, and a page of 0x34 with address 0x8000, then steps across the edge. It also runs an autoinitialise block through two reloads, to show that the terminal count repeats while no mask request appears.

// File: rtl/isa_dma_addr_seq.sv
module isa_dma_addr_seq #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_wide,
  input  logic [1:0]        cfg_win_sel,
  input  logic              plat_pci,
  input  logic              ld_page_en,
  input  logic              ld_addr_en,
  input  logic              ld_cnt_en,
  input  logic              ld_mode_en,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic              mode_auto,
  input  logic              mode_dec,
  input  logic              chan_masked,
  input  logic              stat_rd,
  input  logic              xfer_req,
  output logic              xfer_ack,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              tc_pulse,
  output logic              mask_req,
  output logic              tc_flag,
  output logic [ADDR_W-1:0] cur_cnt
);

  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;
  logic              auto_q, dec_q, tc_flag_q;
  logic              win128, last;
  logic [ADDR_W-1:0] addr_step;

  assign win128    = (cfg_win_sel == 2'd1) | ((cfg_win_sel != 2'd2) & ~plat_pci);
  assign xfer_ack  = xfer_req & ~chan_masked;
  assign last      = xfer_ack & (cur_cnt_q == '0);
  assign tc_pulse  = last;
  assign mask_req  = last & ~auto_q;
  assign tc_flag   = tc_flag_q;
  assign cur_cnt   = cur_cnt_q;
  assign addr_step = dec_q ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;

  always_comb begin
    if (!chan_wide)
      phys_addr = {page_q, cur_addr_q};
    else if (win128)
      phys_addr = {page_q[PAGE_W-1:1], cur_addr_q, 1'b0};
    else
      phys_addr = {page_q, cur_addr_q[ADDR_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q      <= '0;
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      auto_q      <= 1'b0;
      dec_q       <= 1'b0;
      tc_flag_q   <= 1'b0;
    end else begin
      if (ld_page_en) page_q <= ld_data[PAGE_W-1:0];
      if (ld_mode_en) begin
        auto_q <= mode_auto;
        dec_q  <= mode_dec;
      end
      if (ld_addr_en) begin
        base_addr_q <= ld_data;
        cur_addr_q  <= ld_data;
      end else if (xfer_ack) begin
        cur_addr_q <= (last && auto_q) ? base_addr_q : addr_step;
      end
      if (ld_cnt_en) begin
        base_cnt_q <= ld_data;
        cur_cnt_q  <= ld_data;
      end else if (xfer_ack) begin
        if (last) cur_cnt_q <= auto_q ? base_cnt_q : '1;
        else      cur_cnt_q <= cur_cnt_q - 1'b1;
      end
      if (last)         tc_flag_q <= 1'b1;
      else if (stat_rd) tc_flag_q <= 1'b0;
    end
  end

  p_masked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_masked && !ld_addr_en && !ld_cnt_en) |=> ($stable(cur_addr_q) && $stable(cur_cnt_q)));

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && cur_cnt_q != '0 && !ld_cnt_en) |=> (cur_cnt_q == $past(cur_cnt_q) - 1'b1));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && auto_q && !ld_cnt_en && !ld_addr_en) |=>
      (cur_cnt_q == base_cnt_q && cur_addr_q == base_addr_q));

  p_end_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !auto_q && !ld_cnt_en) |=> (cur_cnt_q == '1));

  p_tc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> tc_flag);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_flag && !stat_rd) |=> tc_flag);

endmodule

// File: tb/isa_dma_addr_seq_tb_top.sv
module isa_dma_addr_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic chan_wide = 0, plat_pci = 0, ld_page_en = 0, ld_addr_en = 0, ld_cnt_en = 0, ld_mode_en = 0;
  logic [1:0] cfg_win_sel = 0;
  logic [15:0] ld_data = 0;
  logic mode_auto = 0, mode_dec = 0, chan_masked = 0, stat_rd = 0, xfer_req = 0;
  logic xfer_ack, tc_pulse, mask_req, tc_flag;
  logic [23:0] phys_addr;
  logic [15:0] cur_cnt;

  int checks = 0, errors = 0;
  logic [25:0] expq[$];
  logic [7:0] m_page = 0;
  logic [15:0] m_addr = 0, m_base_addr = 0, m_cnt = 0, m_base_cnt = 0;
  logic m_auto = 0, m_dec = 0;

  always #4 clk = ~clk;

  isa_dma_addr_seq dut_i (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_phys();
    logic w128;
    w128 = (cfg_win_sel == 2'd1) || ((cfg_win_sel != 2'd2) && !plat_pci);
    if (!chan_wide) return {m_page, m_addr};
    if (w128) return {m_page[7:1], m_addr, 1'b0};
    return {m_page, m_addr[14:0], 1'b0};
  endfunction

  task automatic load(input int which, input logic [15:0] v);
    @(negedge clk);
    ld_data = v;
    case (which)
      0: begin ld_page_en = 1; m_page = v[7:0]; end
      1: begin ld_addr_en = 1; m_addr = v; m_base_addr = v; end
      default: begin ld_cnt_en = 1; m_cnt = v; m_base_cnt = v; end
    endcase
    @(negedge clk);
    ld_page_en = 0; ld_addr_en = 0; ld_cnt_en = 0;
  endtask

  task automatic set_mode(input logic a, input logic d);
    @(negedge clk);
    mode_auto = a; mode_dec = d; ld_mode_en = 1; m_auto = a; m_dec = d;
    @(negedge clk);
    ld_mode_en = 0;
  endtask

  task automatic xfer();
    logic lst;
    @(negedge clk);
    lst = (m_cnt == 0);
    expq.push_back({exp_phys(), lst, lst && !m_auto});
    if (lst && m_auto) begin
      m_addr = m_base_addr; m_cnt = m_base_cnt;
    end else begin
      m_addr = m_dec ? m_addr - 1 : m_addr + 1;
      m_cnt = lst ? 16'hFFFF : m_cnt - 1;
    end
    xfer_req = 1;
    @(negedge clk);
    xfer_req = 0;
  endtask

  initial begin : monitor
    logic [25:0] e;
    forever begin
      @(negedge clk);
      #3;
      if (xfer_ack) begin
        if (expq.size() == 0) chk(0, "R11 unexpected ack", 1, 0);
        else begin
          e = expq.pop_front();
          chk(phys_addr == e[25:2], "R2/R4/R5 phys_addr", phys_addr, e[25:2]);
          chk(tc_pulse == e[1], "R7 tc_pulse", tc_pulse, e[1]);
          chk(mask_req == e[0], "R9 mask_req", mask_req, e[0]);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(phys_addr == 0, "R1 reset phys", phys_addr, 0);
    chk(cur_cnt == 0, "R1 reset count", cur_cnt, 0);
    chk(tc_flag == 0, "R1 reset flag", tc_flag, 0);
    chk(xfer_ack == 0, "R1 reset ack", xfer_ack, 0);

    // R2 R3 R9: 8-bit increment across 64K wrap, count 3 -> 4 transfers
    load(0, 16'h0012); load(1, 16'hFFFE); load(2, 16'd3);
    repeat (4) xfer();
    #3;
    chk(cur_cnt == 16'hFFFF, "R9 count after end", cur_cnt, 16'hFFFF);
    chk(phys_addr == 24'h120002, "R9 address stepped", phys_addr, 24'h120002);
    chk(tc_flag == 1, "R10 flag set", tc_flag, 1);

    // R10: held until status read
    load(2, 16'd5); xfer(); #3;
    chk(tc_flag == 1, "R10 flag holds", tc_flag, 1);
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0; #3;
    chk(tc_flag == 0, "R10 flag cleared", tc_flag, 0);

    // R3: decrement across zero
    set_mode(0, 1); load(1, 16'h0001); load(2, 16'd2);
    repeat (3) xfer();

    // R4: 16-bit forced 128K, page 0x35 addr FFFF -> wraps within 128K
    set_mode(0, 0); chan_wide = 1; cfg_win_sel = 2'd1;
    load(0, 16'h0035); load(1, 16'hFFFF); load(2, 16'd1);
    repeat (2) xfer();

    // R5: forced 64K, addr 7FFF -> 8000 wraps in 64K keeping page
    cfg_win_sel = 2'd2; load(1, 16'h7FFF); load(2, 16'd1);
    repeat (2) xfer();
    #3;
    chk(phys_addr == 24'h350002, "R5 bit15 ignored", phys_addr, 24'h350002);

    // R6: automatic selection with page 0x34 addr 8000
    load(0, 16'h0034);
    cfg_win_sel = 2'd0; plat_pci = 1; load(1, 16'h8000); #3;
    chk(phys_addr == 24'h340000, "R6 auto pci 64K", phys_addr, 24'h340000);
    plat_pci = 0; #1;
    chk(phys_addr == 24'h350000, "R6 auto no-pci 128K", phys_addr, 24'h350000);
    cfg_win_sel = 2'd3; plat_pci = 1; #1;
    chk(phys_addr == 24'h340000, "R6 sel3 auto", phys_addr, 24'h340000);
    load(2, 16'd0); xfer();

    // R8: autoinit 8-bit, count 1, two reloads
    chan_wide = 0; set_mode(1, 0);
    load(0, 16'h0007); load(1, 16'h0100); load(2, 16'd1);
    repeat (5) xfer();
    #3;
    chk(cur_cnt == 16'd0, "R8 count after reloads", cur_cnt, 0);

    // R11: masked channel ignores strobes
    chan_masked = 1;
    @(negedge clk); xfer_req = 1; #3;
    chk(xfer_ack == 0, "R11 no ack", xfer_ack, 0);
    @(negedge clk); xfer_req = 0; #3;
    chk(cur_cnt == 16'd0, "R11 count held", cur_cnt, 0);
    chk(phys_addr == 24'h070101, "R11 addr held", phys_addr, 24'h070101);
    chan_masked = 0;

    // R12: load beats a transfer in the same cycle
    @(negedge clk); ld_data = 16'h0200; ld_addr_en = 1; xfer_req = 1;
    expq.push_back({24'h070101, 1'b1, 1'b0});
    @(negedge clk); ld_addr_en = 0; xfer_req = 0; #3;
    chk(phys_addr == 24'h070200, "R12 load priority", phys_addr, 24'h070200);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R7 all expected transfers seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule